// File: doc/BRIEF.md
# Command/Response Buffer Register Interface

This block is the register front end of a security-module command/response buffer interface. A host accesses it over a simple memory-mapped port. Each write carries a full data word, and the write only has an effect when that word is one exact single-bit command value. Reads are combinational and return the addressed 32-bit register shifted right to the byte offset of the access, so 1-, 2- and 4-byte little-endian reads all work.

The block keeps three kinds of state. The first is locality ownership (assigned/granted). The second is the ready/idle state and a sticky fatal-error flag. The third is the in-flight command bit that pairs with the start/cancel handshake. An accepted start produces a one-cycle `start_req` pulse to a back-end engine, together with the command length. The block derives that length from the size field in the command header and clamps it to the usable buffer size. A cancel produces a one-cycle `cancel_pulse`. The engine finishes a command with `done_strobe` and may raise `done_err` at the same time. The data buffer memory and the command processing live outside this block.

Top module: `cmdbuf_regif`

## Requirements
- R1: A write to the request register (offset 0x040) with value 1 clears the idle flag, and a write with value 2 sets it. Every other value leaves the flag unchanged. The idle flag reads as bit 1 of the status register (offset 0x044).
- R2: A write of value 1 to the start register (offset 0x04C) is accepted only when all three of these hold: the in-flight bit is clear, a locality is assigned, and the active locality equals write address bits [15:12]. An accepted start sets the in-flight bit, which reads as bit 0 of offset 0x04C. On the clock edge of the write it also raises `start_req` for exactly one cycle.
- R3: A write of value 1 to the cancel register (offset 0x048) raises `cancel_pulse` for one cycle, but only while the in-flight bit is set. In every other case the write has no effect.
- R4: `done_strobe` clears the in-flight bit. If `done_err` is high with the strobe, bit 0 of the status register is set and stays set until reset.
- R5: In the locality-control register (offset 0x008), value 1 sets the granted bit and the assigned bit and clears the seized bit. Value 2 clears the assigned bit and the granted bit. All other values, including 4 and 8, are ignored. Granted reads as bit 0 and seized as bit 1 of offset 0x00C. Assigned reads as bit 1 of offset 0x000.
- R6: `active_loc` reads 0xFF while no locality is assigned. Otherwise it shows the stored active-locality field, which resets to 0 and has no write path.
- R7: Read data is the register at the word-aligned offset (address bits [11:0]), shifted right by 8 times address bits [1:0]. A read at exactly offset 0x000 also ORs the inverse of `established` into bit 0. Unmapped offsets read 0.
- R8: After reset, the following hold. Offset 0x000 reads 0x80 (valid bit 7) when `established` is high. The status register reads 0x2. The interface-ID register (offset 0x030) reads 0x6C11: type 1 in [3:0], version 1 in [7:4], transfer code 3 in [11:10], buffer-capability bit 13, selector 1 in [15:14].
- R9: After reset, the command-size register (0x058) and the response-size register (0x064) both hold the buffer size, WINDOW_BYTES−BUF_OFFSET (0xF80 by default). The command-address register (0x05C) and the response-address register (0x068) both hold BASE_ADDR+BUF_OFFSET.
- R10: On an accepted start, `cmd_len` is loaded with the smaller of two values: the big-endian 32-bit size taken from header bytes 2..5 (byte n in `cmd_hdr[8n+7:8n]`), and the effective back-end buffer size. `rsp_len` always equals the effective buffer size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 16 | Write address; [15:12] locality, [11:0] offset |
| wr_data | input | 32 | Write data word |
| rd_addr | input | 16 | Read address |
| rd_data | output | 32 | Read data, shifted to byte offset |
| established | input | 1 | Back-end established flag |
| cmd_hdr | input | 48 | First six bytes of the command buffer |
| start_req | output | 1 | One-cycle command request to back end |
| cancel_pulse | output | 1 | One-cycle cancel to back end |
| cmd_len | output | 32 | Command length captured at start |
| rsp_len | output | 32 | Response length available |
| done_strobe | input | 1 | Back-end completion strobe |
| done_err | input | 1 | Completion carries an error |
| active_loc | output | 8 | Active locality or 0xFF |

## Verification
Several conditions are hard to reach from the ports. Examples are a second start while a command is in flight, a start from a non-matching locality, and a cancel with nothing in flight. Each needs the locality and in-flight state set up first. The stimulus therefore runs as an ordered session. It first issues starts and cancels before any locality is assigned. It then requests access, tries a start from the locality-1 address window, issues a proper start, and repeats start and cancel while the back end holds the completion back. Finally, a completion with the error flag, given after a start whose header size exceeds the buffer, exercises both the clamp and the sticky fatal bit.

// File: rtl/cmdbuf_pkg.sv
package cmdbuf_pkg;
   localparam int OFS_W = 12;
   localparam logic [11:0] OFS_LOC_STATE = 12'h000;
   localparam logic [11:0] OFS_LOC_CTRL  = 12'h008;
   localparam logic [11:0] OFS_LOC_STS   = 12'h00C;
   localparam logic [11:0] OFS_INTF_ID   = 12'h030;
   localparam logic [11:0] OFS_REQ       = 12'h040;
   localparam logic [11:0] OFS_STS       = 12'h044;
   localparam logic [11:0] OFS_CANCEL    = 12'h048;
   localparam logic [11:0] OFS_START     = 12'h04C;
   localparam logic [11:0] OFS_CMD_SIZE  = 12'h058;
   localparam logic [11:0] OFS_CMD_ADDR  = 12'h05C;
   localparam logic [11:0] OFS_RSP_SIZE  = 12'h064;
   localparam logic [11:0] OFS_RSP_ADDR  = 12'h068;

   localparam logic [31:0] CMD_READY  = 32'd1;
   localparam logic [31:0] CMD_IDLE   = 32'd2;
   localparam logic [31:0] CMD_INVOKE = 32'd1;
   localparam logic [31:0] LOC_ASK    = 32'd1;
   localparam logic [31:0] LOC_DROP   = 32'd2;

   localparam logic [7:0] NO_LOC = 8'hFF;

   function automatic logic [31:0] intf_id_word();
      logic [31:0] w;
      w        = '0;
      w[3:0]   = 4'd1;   // interface kind: buffer active
      w[7:4]   = 4'd1;   // interface version
      w[8]     = 1'b0;   // locality 0 only
      w[9]     = 1'b0;   // no fast idle bypass
      w[11:10] = 2'b11;  // 64-byte transfers
      w[12]    = 1'b0;   // no FIFO path
      w[13]    = 1'b1;   // buffer path present
      w[15:14] = 2'd1;   // selector: buffer
      w[27:24] = 4'd0;   // revision
      return w;
   endfunction
endpackage

// File: rtl/cmdbuf_loc.sv
module cmdbuf_loc #(
   parameter int LOC_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctrl_wr,
   input  logic [31:0]      wdata,
   output logic             granted,
   output logic             seized,
   output logic             assigned,
   output logic [LOC_W-1:0] loc_field,
   output logic [7:0]       active_loc
);
   import cmdbuf_pkg::*;

   if (LOC_W < 1 || LOC_W > 5) begin : g_bad_locw
      $error("cmdbuf_loc: LOC_W must be 1..5");
   end

   // The locality field has no write path; it stays at its reset value.
   assign loc_field = '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         granted  <= 1'b0;
         seized   <= 1'b0;
         assigned <= 1'b0;
      end else if (ctrl_wr) begin
         if (wdata == LOC_ASK) begin
            granted  <= 1'b1;
            seized   <= 1'b0;
            assigned <= 1'b1;
         end else if (wdata == LOC_DROP) begin
            granted  <= 1'b0;
            assigned <= 1'b0;
         end
      end
   end

   assign active_loc = assigned ? 8'(loc_field) : NO_LOC;
endmodule

// File: rtl/cmdbuf_ctrl.sv
module cmdbuf_ctrl #(
   parameter int          LOC_ADDR_W = 4,
   parameter logic [31:0] EFF_LEN    = 32'hF80,
   parameter bit          CLAMP_LEN  = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_wr,
   input  logic                  start_wr,
   input  logic                  cancel_wr,
   input  logic [31:0]           wdata,
   input  logic [LOC_ADDR_W-1:0] wr_loc,
   input  logic [7:0]            active_loc,
   input  logic                  done_strobe,
   input  logic                  done_err,
   input  logic [31:0]           hdr_len,
   output logic                  idle,
   output logic                  fatal,
   output logic                  busy,
   output logic                  start_req,
   output logic                  cancel_pulse,
   output logic [31:0]           cmd_len
);
   import cmdbuf_pkg::*;

   logic        accept;
   logic [31:0] len_next;

   assign accept = start_wr && (wdata == CMD_INVOKE) && !busy
                   && (active_loc == 8'(wr_loc));

   if (CLAMP_LEN) begin : g_clamp
      assign len_next = (hdr_len < EFF_LEN) ? hdr_len : EFF_LEN;
   end else begin : g_raw
      assign len_next = hdr_len;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idle         <= 1'b1;
         fatal        <= 1'b0;
         busy         <= 1'b0;
         start_req    <= 1'b0;
         cancel_pulse <= 1'b0;
         cmd_len      <= '0;
      end else begin
         start_req    <= accept;
         cancel_pulse <= cancel_wr && (wdata == CMD_INVOKE) && busy;
         if (req_wr && wdata == CMD_READY) idle <= 1'b0;
         else if (req_wr && wdata == CMD_IDLE) idle <= 1'b1;
         if (done_strobe && done_err) fatal <= 1'b1;
         if (accept) begin
            busy    <= 1'b1;
            cmd_len <= len_next;
         end else if (done_strobe) begin
            busy <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/cmdbuf_rdmux.sv
module cmdbuf_rdmux #(
   parameter int          LOC_W    = 3,
   parameter logic [31:0] EFF_LEN  = 32'hF80,
   parameter logic [31:0] BUF_SIZE = 32'hF80,
   parameter logic [31:0] BUF_ADDR = 32'hFED4_0080
) (
   input  logic [11:0]      rd_ofs,
   input  logic             established,
   input  logic             granted,
   input  logic             seized,
   input  logic             assigned,
   input  logic [LOC_W-1:0] loc_field,
   input  logic             idle,
   input  logic             fatal,
   input  logic             busy,
   output logic [31:0]      rd_data
);
   import cmdbuf_pkg::*;

   logic [31:0] word;
   logic [11:0] aligned;

   assign aligned = {rd_ofs[11:2], 2'b00};

   always_comb begin
      word = '0;
      case (aligned)
         OFS_LOC_STATE: begin
            word[1]         = assigned;
            word[2 +: LOC_W] = loc_field;
            word[7]         = 1'b1;
         end
         OFS_LOC_STS:  word[1:0] = {seized, granted};
         OFS_INTF_ID:  word      = intf_id_word();
         OFS_STS:      word[1:0] = {idle, fatal};
         OFS_START:    word[0]   = busy;
         OFS_CMD_SIZE: word      = BUF_SIZE;
         OFS_CMD_ADDR: word      = BUF_ADDR;
         OFS_RSP_SIZE: word      = BUF_SIZE;
         OFS_RSP_ADDR: word      = BUF_ADDR;
         default:      word      = '0;
      endcase
      rd_data = word >> (8 * rd_ofs[1:0]);
      if (rd_ofs == OFS_LOC_STATE) rd_data[0] = rd_data[0] | !established;
   end
endmodule

// File: rtl/cmdbuf_regif.sv
module cmdbuf_regif #(
   parameter logic [31:0] BASE_ADDR    = 32'hFED4_0000,
   parameter int          ADDR_W       = 16,
   parameter int          WINDOW_BYTES = 4096,
   parameter int          BUF_OFFSET   = 128,
   parameter int          BE_BUF_BYTES = 4096,
   parameter int          LOC_W        = 3,
   parameter bit          CLAMP_LEN    = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [15:0] wr_addr,
   input  logic [31:0] wr_data,
   input  logic [15:0] rd_addr,
   output logic [31:0] rd_data,
   input  logic        established,
   input  logic [47:0] cmd_hdr,
   output logic        start_req,
   output logic        cancel_pulse,
   output logic [31:0] cmd_len,
   output logic [31:0] rsp_len,
   input  logic        done_strobe,
   input  logic        done_err,
   output logic [7:0]  active_loc
);
   import cmdbuf_pkg::*;

   localparam int          LOC_ADDR_W = ADDR_W - OFS_W;
   localparam int          BUF_BYTES  = WINDOW_BYTES - BUF_OFFSET;
   localparam int          EFF_BYTES  = (BE_BUF_BYTES < BUF_BYTES) ? BE_BUF_BYTES : BUF_BYTES;
   localparam logic [31:0] BUF_SIZE   = 32'(BUF_BYTES);
   localparam logic [31:0] EFF_LEN    = 32'(EFF_BYTES);
   localparam logic [31:0] BUF_ADDR   = BASE_ADDR + 32'(BUF_OFFSET);

   if (ADDR_W != 16) begin : g_bad_addr
      $error("cmdbuf_regif: ADDR_W must be 16");
   end
   if (BUF_OFFSET <= 32'(OFS_RSP_ADDR) || BUF_OFFSET >= WINDOW_BYTES || (BUF_OFFSET % 4) != 0) begin : g_bad_ofs
      $error("cmdbuf_regif: BUF_OFFSET must be word aligned, above the registers and inside the window");
   end
   if (BE_BUF_BYTES < 6) begin : g_bad_be
      $error("cmdbuf_regif: BE_BUF_BYTES too small for a header");
   end

   logic        granted, seized, assigned, idle, fatal, busy;
   logic [LOC_W-1:0] loc_field;
   logic [11:0] wofs;
   logic [31:0] hdr_len;

   assign wofs    = wr_addr[OFS_W-1:0];
   assign hdr_len = {cmd_hdr[23:16], cmd_hdr[31:24], cmd_hdr[39:32], cmd_hdr[47:40]};
   assign rsp_len = EFF_LEN;

   cmdbuf_loc #(.LOC_W(LOC_W)) u_loc (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctrl_wr    (wr_en && wofs == OFS_LOC_CTRL),
      .wdata      (wr_data),
      .granted    (granted),
      .seized     (seized),
      .assigned   (assigned),
      .loc_field  (loc_field),
      .active_loc (active_loc)
   );

   cmdbuf_ctrl #(.LOC_ADDR_W(LOC_ADDR_W), .EFF_LEN(EFF_LEN), .CLAMP_LEN(CLAMP_LEN)) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_wr       (wr_en && wofs == OFS_REQ),
      .start_wr     (wr_en && wofs == OFS_START),
      .cancel_wr    (wr_en && wofs == OFS_CANCEL),
      .wdata        (wr_data),
      .wr_loc       (wr_addr[ADDR_W-1:OFS_W]),
      .active_loc   (active_loc),
      .done_strobe  (done_strobe),
      .done_err     (done_err),
      .hdr_len      (hdr_len),
      .idle         (idle),
      .fatal        (fatal),
      .busy         (busy),
      .start_req    (start_req),
      .cancel_pulse (cancel_pulse),
      .cmd_len      (cmd_len)
   );

   cmdbuf_rdmux #(.LOC_W(LOC_W), .EFF_LEN(EFF_LEN), .BUF_SIZE(BUF_SIZE), .BUF_ADDR(BUF_ADDR)) u_rd (
      .rd_ofs      (rd_addr[OFS_W-1:0]),
      .established (established),
      .granted     (granted),
      .seized      (seized),
      .assigned    (assigned),
      .loc_field   (loc_field),
      .idle        (idle),
      .fatal       (fatal),
      .busy        (busy),
      .rd_data     (rd_data)
   );
endmodule

// File: rtl/cmdbuf_regif_chk.sv
module cmdbuf_regif_chk #(
   parameter logic [31:0] EFF_LEN = 32'hF80
) (
   input logic        clk,
   input logic        rst_n,
   input logic        wr_en,
   input logic [15:0] wr_addr,
   input logic [31:0] wr_data,
   input logic        start_req,
   input logic        cancel_pulse,
   input logic        done_strobe,
   input logic        done_err,
   input logic        busy,
   input logic        idle,
   input logic        fatal,
   input logic [7:0]  active_loc,
   input logic [31:0] cmd_len
);
   import cmdbuf_pkg::*;

   assert_go_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr[11:0] == OFS_REQ && wr_data == 32'd2) |=> idle);

   assert_start_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
      start_req |-> $past(wr_en && wr_addr[11:0] == OFS_START && wr_data == 32'd1 && !busy));

   assert_start_flight_R2: assert property (@(posedge clk) disable iff (!rst_n)
      start_req |-> busy);

   assert_cancel_flight_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cancel_pulse |-> $past(busy));

   assert_done_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (done_strobe && !(wr_en && wr_addr[11:0] == OFS_START)) |=> !busy);

   assert_fatal_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (done_strobe && done_err) |=> fatal);

   assert_loc_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (active_loc == 8'hFF) || (active_loc < 8'd32));

   assert_len_clamp_R10: assert property (@(posedge clk) disable iff (!rst_n)
      start_req |-> (cmd_len <= EFF_LEN));
endmodule

bind cmdbuf_regif cmdbuf_regif_chk #(.EFF_LEN(EFF_LEN)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .wr_en        (wr_en),
   .wr_addr      (wr_addr),
   .wr_data      (wr_data),
   .start_req    (start_req),
   .cancel_pulse (cancel_pulse),
   .done_strobe  (done_strobe),
   .done_err     (done_err),
   .busy         (busy),
   .idle         (idle),
   .fatal        (fatal),
   .active_loc   (active_loc),
   .cmd_len      (cmd_len)
);

// File: tb/test_cmdbuf_regif.sv
module test_cmdbuf_regif;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [15:0] rd_addr = '0;
   logic [31:0] rd_data;
   logic        established = 1'b1;
   logic [47:0] cmd_hdr = '0;
   logic        start_req, cancel_pulse;
   logic [31:0] cmd_len, rsp_len;
   logic        done_strobe = 1'b0;
   logic        done_err = 1'b0;
   logic [7:0]  active_loc;

   int checks = 0;
   int errors = 0;
   logic saw_start, saw_cancel;

   localparam logic [31:0] EFF  = 32'hF80;
   localparam logic [31:0] BADR = 32'hFED4_0080;

   cmdbuf_regif i_cmdbuf_regif (.*);

   always #5 clk = ~clk;

   initial begin
      #1_000_000;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [15:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      saw_start = start_req;
      saw_cancel = cancel_pulse;
   endtask

   task automatic rd(input logic [15:0] a, output logic [31:0] d);
      @(negedge clk);
      rd_addr = a;
      #1 d = rd_data;
   endtask

   task automatic done(input logic e);
      @(negedge clk);
      done_strobe = 1'b1; done_err = e;
      @(negedge clk);
      done_strobe = 1'b0; done_err = 1'b0;
   endtask

   function automatic logic [47:0] hdr(input logic [31:0] s);
      return {s[7:0], s[15:8], s[23:16], s[31:24], 16'h0000};
   endfunction

   initial begin
      logic [31:0] v;
      logic        idle_m;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R8 / R9 reset state
      rd(16'h000, v); check("R8 loc state", v, 32'h80);
      rd(16'h044, v); check("R8 status", v, 32'h2);
      rd(16'h030, v); check("R8 intf id", v, 32'h6C11);
      rd(16'h058, v); check("R9 cmd size", v, EFF);
      rd(16'h064, v); check("R9 rsp size", v, EFF);
      rd(16'h05C, v); check("R9 cmd addr", v, BADR);
      rd(16'h068, v); check("R9 rsp addr", v, BADR);
      check("R6 none assigned", 32'(active_loc), 32'hFF);
      check("R10 rsp len", rsp_len, EFF);

      // R7 byte-offset sweep
      for (int k = 0; k < 4; k++) begin
         rd(16'h030 + 16'(k), v); check("R7 intf shift", v, 32'h6C11 >> (8 * k));
         rd(16'h05C + 16'(k), v); check("R7 addr shift", v, BADR >> (8 * k));
      end
      established = 1'b0;
      rd(16'h000, v); check("R7 established merge", v, 32'h81);
      rd(16'h001, v); check("R7 no merge off 1", v, 32'h0);
      rd(16'h0F0, v); check("R7 unmapped", v, 32'h0);
      established = 1'b1;

      // R1 request-register sweep
      idle_m = 1'b1;
      for (int x = 0; x < 8; x++) begin
         wr(16'h040, 32'(x));
         if (x == 1) idle_m = 1'b0;
         else if (x == 2) idle_m = 1'b1;
         rd(16'h044, v); check("R1 idle", v, {30'd0, idle_m, 1'b0});
      end
      wr(16'h040, 32'h101);
      rd(16'h044, v); check("R1 wide value ignored", v, {30'd0, idle_m, 1'b0});

      // R2 start with no locality
      cmd_hdr = hdr(32'h20);
      wr(16'h04C, 32'h1);
      check("R2 no locality pulse", 32'(saw_start), 32'h0);
      rd(16'h04C, v); check("R2 no locality bit", v, 32'h0);

      // R3 cancel while idle
      wr(16'h048, 32'h1);
      check("R3 cancel idle", 32'(saw_cancel), 32'h0);

      // R5 request access
      wr(16'h008, 32'h1);
      rd(16'h00C, v); check("R5 granted", v, 32'h1);
      rd(16'h000, v); check("R5 assigned", v, 32'h82);
      check("R6 active loc", 32'(active_loc), 32'h0);

      // R2 mismatched locality, wrong value
      wr(16'h104C, 32'h1);
      check("R2 loc mismatch", 32'(saw_start), 32'h0);
      wr(16'h004C, 32'h3);
      check("R2 value 3", 32'(saw_start), 32'h0);
      rd(16'h04C, v); check("R2 still clear", v, 32'h0);

      // R2 / R10 accepted start
      wr(16'h004C, 32'h1);
      check("R2 start pulse", 32'(saw_start), 32'h1);
      check("R10 cmd len", cmd_len, 32'h20);
      @(negedge clk);
      check("R2 pulse one cycle", 32'(start_req), 32'h0);
      rd(16'h04C, v); check("R2 in flight", v, 32'h1);

      // R2 second start while busy
      cmd_hdr = hdr(32'h40);
      wr(16'h004C, 32'h1);
      check("R2 busy start", 32'(saw_start), 32'h0);
      check("R10 len held", cmd_len, 32'h20);

      // R3 cancel while busy
      wr(16'h048, 32'h2);
      check("R3 cancel value 2", 32'(saw_cancel), 32'h0);
      wr(16'h048, 32'h1);
      check("R3 cancel pulse", 32'(saw_cancel), 32'h1);

      // R4 completion without error
      done(1'b0);
      rd(16'h04C, v); check("R4 cleared", v, 32'h0);
      rd(16'h044, v); check("R4 no fatal", v, {30'd0, idle_m, 1'b0});

      // R10 clamp, R4 error completion
      cmd_hdr = hdr(32'h0001_2345);
      wr(16'h004C, 32'h1);
      check("R10 clamp pulse", 32'(saw_start), 32'h1);
      check("R10 clamped len", cmd_len, EFF);
      done(1'b1);
      rd(16'h044, v); check("R4 fatal set", v, {30'd0, idle_m, 1'b1});
      wr(16'h040, 32'h1);
      rd(16'h044, v); check("R4 fatal sticky", v, 32'h1);

      // R5 ignored codes then relinquish
      wr(16'h008, 32'h4);
      wr(16'h008, 32'h8);
      rd(16'h00C, v); check("R5 seize ignored", v, 32'h1);
      wr(16'h008, 32'h2);
      rd(16'h00C, v); check("R5 relinquish", v, 32'h0);
      rd(16'h000, v); check("R5 unassigned", v, 32'h80);
      check("R6 back to none", 32'(active_loc), 32'hFF);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule